// File: doc/BRIEF.md
# Linear Chirp Pulse Generator

This block synthesises a linear-FM baseband pulse for a pulsed transmitter. While transmit is enabled, a frequency word is stepped by a constant increment on every clock. That word drives a phase accumulator, and a pipelined CORDIC rotator turns the phase and a signed amplitude into I/Q samples. The start word is normally a negative value of half the sweep width, so the sweep passes through zero offset at mid-pulse and is symmetric about the carrier.

A controller holds `tx_en` high for the length of the pulse. It may pulse `pulse_start` to restart the sweep without breaking phase continuity. The amplitude reaches the rotator unchanged, so any gain compensation has to be folded into it beforehand. All accumulation wraps modulo 2^FREQ_W.

Top module: `chirp_pulse_gen`

## Requirements
- R1: While reset is high, and afterwards while `tx_en` stays low, `sample_valid` is 0 and both `sample_i` and `sample_q` are 0.
- R2: On the first clock edge with `tx_en` high after it was low, the frequency word loads `start_word`. On each later enabled edge, `incr_word` is added to it. The phase accumulator adds the frequency word held before each enabled edge, and starts from 0, so the sample phases are 0, S, 2S+D, 3S+3D, and so on.
- R3: With `tx_en` high, `pulse_start`=1 reloads the frequency word with `start_word` on that edge, and the phase accumulator carries on from its current value.
- R4: Each valid sample equals A·G/2·cos θ on `sample_i` and A·G/2·sin θ on `sample_q`, within ±10 LSB. A is the signed `amplitude`, used without rescaling. G is the CORDIC gain, the product over k<STAGES of sqrt(1+2^-2k). θ = 2π·P/2^ANG_W, where P is the top ANG_W bits of the phase accumulator.
- R5: Angles in all four quadrants are rotated correctly, including downward sweeps from a negative start word.
- R6: `sample_valid` rises on the (STAGES+3)th rising edge, counting the first edge that samples `tx_en`=1 as the first. It stays low on every earlier edge.
- R7: On the first edge with `tx_en` low, `sample_valid`, `sample_i` and `sample_q` go to 0, both accumulators clear and samples in flight are discarded. A later enable starts again from phase 0 and the full latency.
- R8: Frequency and phase arithmetic wraps modulo 2^FREQ_W with no saturation.
- R9: A negative amplitude, including the most negative code, inverts both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; high for the pulse duration |
| pulse_start | input | 1 | Reloads the frequency word with the start value |
| start_word | input | FREQ_W | Two's complement start frequency word |
| incr_word | input | FREQ_W | Frequency word step per clock |
| amplitude | input | AMP_W | Signed magnitude fed to the rotator |
| sample_i | output | AMP_W | Signed in-phase sample |
| sample_q | output | AMP_W | Signed quadrature sample |
| sample_valid | output | 1 | Sample qualifier |

## Verification
The bench builds the block with its defaults: 32-bit frequency and phase words, a 16-bit amplitude and angle, and 16 rotator stages. With 32-bit words, start values near 2^31 and increments of 2^30 wrap the accumulators within a few clocks. Steps of a sixteenth of a turn sweep the angle through every quadrant in one short pulse. Sixteen stages give a 19-cycle latency, so the exact edge on which valid first appears, and a flush after a one-cycle gap, both fit inside a pulse of a few dozen cycles.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

  localparam real TWO_PI = 8.0 * $atan(1.0);

  // Rotation angle of stage k, atan(2^-k), in units where 2^zw is a full turn.
  function automatic int atan_code(input int stage, input int zw);
    real a;
    a = $atan(1.0 / (2.0 ** stage));
    return $rtoi(a / TWO_PI * (2.0 ** zw) + 0.5);
  endfunction

  // True when the top two angle bits place the vector in the left half-plane.
  function automatic logic quad_flip(input logic [1:0] top);
    return (top == 2'b01) || (top == 2'b10);
  endfunction

endpackage

// File: rtl/chirp_freq_ramp.sv
module chirp_freq_ramp #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_en,
  input  logic          pulse_start,
  input  logic [FW-1:0] start_word,
  input  logic [FW-1:0] incr_word,
  output logic [FW-1:0] freq_o
);
  logic          en_q;
  logic [FW-1:0] freq_q;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      en_q   <= 1'b0;
      freq_q <= '0;
    end else begin
      en_q <= 1'b1;
      if (pulse_start || !en_q) freq_q <= start_word;
      else                      freq_q <= freq_q + incr_word;
    end
  end

  assign freq_o = freq_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !en_q) |=> (freq_q == $past(start_word)));
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_en && en_q && !pulse_start) |=> (freq_q == $past(freq_q) + $past(incr_word)));
  assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_en && pulse_start) |=> (freq_q == $past(start_word)));
  assert_freq_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (freq_q == '0));
endmodule

// File: rtl/chirp_phase_acc.sv
module chirp_phase_acc #(
  parameter int FW  = 32,
  parameter int AGW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tx_en,
  input  logic [FW-1:0]  freq_i,
  output logic [AGW-1:0] angle_o,
  output logic           vld_o
);
  logic [FW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      phase_q <= '0;
      vld_o   <= 1'b0;
    end else begin
      phase_q <= phase_q + freq_i;
      vld_o   <= 1'b1;
    end
  end

  assign angle_o = phase_q[FW-1 -: AGW];

  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    tx_en |=> (phase_q == $past(phase_q) + $past(freq_i)));
  assert_phase_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (phase_q == '0 && !vld_o));
endmodule

// File: rtl/chirp_cordic.sv
module chirp_cordic #(
  parameter int AW   = 16,
  parameter int AGW  = 16,
  parameter int NSTG = 16,
  localparam int DW  = AW + 2,
  localparam int ZW  = AGW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 vld_i,
  input  logic [AGW-1:0]       ang_i,
  input  logic signed [AW-1:0] mag_i,
  output logic                 vld_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o
);
  logic signed [DW-1:0] xs [NSTG+1];
  logic signed [DW-1:0] ys [NSTG+1];
  logic signed [ZW-1:0] zs [NSTG+1];
  logic                 vs [NSTG+1];

  // Quadrant pre-rotation: a half turn brings any angle into [-90, 90) degrees.
  logic                 flip;
  logic [AGW-1:0]       ang_rot;
  logic signed [DW-1:0] mag_ext;
  logic signed [DW-1:0] xp;
  logic signed [ZW-1:0] zp;
  logic                 vp;

  always_comb begin
    flip    = chirp_pkg::quad_flip(ang_i[AGW-1 -: 2]);
    ang_rot = ang_i ^ {flip, {(AGW-1){1'b0}}};
    mag_ext = DW'(mag_i);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) vp <= 1'b0;
    else              vp <= vld_i;
    xp <= flip ? -mag_ext : mag_ext;
    zp <= {ang_rot, 2'b00};
  end

  assign xs[0] = xp;
  assign ys[0] = '0;
  assign zs[0] = zp;
  assign vs[0] = vp;

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    localparam logic signed [ZW-1:0] ATAN_K = ZW'(chirp_pkg::atan_code(k, ZW));
    logic signed [DW-1:0] xr, yr;
    logic signed [ZW-1:0] zr;
    logic                 vr;

    always_ff @(posedge clk) begin
      if (rst || flush) vr <= 1'b0;
      else              vr <= vs[k];
      if (zs[k][ZW-1]) begin
        xr <= xs[k] + (ys[k] >>> k);
        yr <= ys[k] - (xs[k] >>> k);
        zr <= zs[k] + ATAN_K;
      end else begin
        xr <= xs[k] - (ys[k] >>> k);
        yr <= ys[k] + (xs[k] >>> k);
        zr <= zs[k] - ATAN_K;
      end
    end

    assign xs[k+1] = xr;
    assign ys[k+1] = yr;
    assign zs[k+1] = zr;
    assign vs[k+1] = vr;
  end

  assign x_o   = xs[NSTG];
  assign y_o   = ys[NSTG];
  assign vld_o = vs[NSTG];

  localparam logic signed [ZW-1:0] ZBOUND = ZW'(chirp_pkg::atan_code(NSTG-1, ZW) + NSTG);

  assert_converged_R4: assert property (@(posedge clk) disable iff (rst)
    vs[NSTG] |-> ((zs[NSTG] <= ZBOUND) && (zs[NSTG] >= -ZBOUND)));
  assert_flush_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !vs[NSTG]);
endmodule

// File: rtl/chirp_pulse_gen.sv
module chirp_pulse_gen #(
  parameter int FREQ_W = 32,
  parameter int AMP_W  = 16,
  parameter int ANG_W  = 16,
  parameter int STAGES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tx_en,
  input  logic                    pulse_start,
  input  logic [FREQ_W-1:0]       start_word,
  input  logic [FREQ_W-1:0]       incr_word,
  input  logic signed [AMP_W-1:0] amplitude,
  output logic signed [AMP_W-1:0] sample_i,
  output logic signed [AMP_W-1:0] sample_q,
  output logic                    sample_valid
);
  localparam int DW = AMP_W + 2;

  logic [FREQ_W-1:0]    freq_w;
  logic [ANG_W-1:0]     angle_w;
  logic                 ph_vld;
  logic                 c_vld;
  logic signed [DW-1:0] c_x, c_y;
  logic                 fire;

  chirp_freq_ramp #(.FW(FREQ_W)) u_ramp (
    .clk(clk), .rst(rst), .tx_en(tx_en), .pulse_start(pulse_start),
    .start_word(start_word), .incr_word(incr_word), .freq_o(freq_w)
  );

  chirp_phase_acc #(.FW(FREQ_W), .AGW(ANG_W)) u_phase (
    .clk(clk), .rst(rst), .tx_en(tx_en), .freq_i(freq_w),
    .angle_o(angle_w), .vld_o(ph_vld)
  );

  chirp_cordic #(.AW(AMP_W), .AGW(ANG_W), .NSTG(STAGES)) u_cordic (
    .clk(clk), .rst(rst), .flush(!tx_en), .vld_i(ph_vld),
    .ang_i(angle_w), .mag_i(amplitude),
    .vld_o(c_vld), .x_o(c_x), .y_o(c_y)
  );

  assign fire = tx_en && c_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_valid <= 1'b0;
      sample_i     <= '0;
      sample_q     <= '0;
    end else begin
      sample_valid <= fire;
      sample_i     <= fire ? c_x[AMP_W:1] : '0;
      sample_q     <= fire ? c_y[AMP_W:1] : '0;
    end
  end

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!sample_valid && sample_i == '0 && sample_q == '0));
  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $past(tx_en));
  assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> (sample_i == '0 && sample_q == '0));
endmodule

// File: tb/chirp_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module chirp_pulse_gen_tb_top;
  localparam int FW  = 32;
  localparam int AW  = 16;
  localparam int AGW = 16;
  localparam int NS  = 16;
  localparam int LAT = NS + 3;
  localparam real TOL = 10.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0;
  logic pulse_start = 1'b0;
  logic [FW-1:0] start_word = '0;
  logic [FW-1:0] incr_word = '0;
  logic signed [AW-1:0] amplitude = '0;
  logic signed [AW-1:0] sample_i, sample_q;
  logic sample_valid;

  always #2 clk = ~clk;

  chirp_pulse_gen #(.FREQ_W(FW), .AMP_W(AW), .ANG_W(AGW), .STAGES(NS)) dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .pulse_start(pulse_start),
    .start_word(start_word), .incr_word(incr_word), .amplitude(amplitude),
    .sample_i(sample_i), .sample_q(sample_q), .sample_valid(sample_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  real gain_half;
  real exp_i[$];
  real exp_q[$];
  string exp_t[$];
  logic [FW-1:0] m_freq = '0;
  logic [FW-1:0] m_phase = '0;
  bit m_en = 1'b0;

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic push_expect(input logic [FW-1:0] ph, input string tag);
    real th;
    th = chirp_pkg::TWO_PI * real'(ph[FW-1 -: AGW]) / (2.0 ** AGW);
    exp_i.push_back(real'(amplitude) * gain_half * $cos(th));
    exp_q.push_back(real'(amplitude) * gain_half * $sin(th));
    exp_t.push_back(tag);
  endtask

  task automatic check_valid(input bit expv, input string tag);
    checks++;
    if (sample_valid !== expv) begin
      errors++;
      $display("FAIL %s latency: actual valid=%0b expected valid=%0b", tag, sample_valid, expv);
    end
  endtask

  // Scoreboard monitor: pops one expectation per valid sample.
  real ei, eq;
  string et;
  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (sample_valid) begin
        if (exp_i.size() == 0) begin
          errors++;
          $display("FAIL R6 unexpected sample: actual I=%0d Q=%0d expected no sample", sample_i, sample_q);
        end else begin
          ei = exp_i.pop_front();
          eq = exp_q.pop_front();
          et = exp_t.pop_front();
          if (absr(real'(sample_i) - ei) > TOL || absr(real'(sample_q) - eq) > TOL) begin
            errors++;
            $display("FAIL %s sample: actual I=%0d Q=%0d expected I=%0.1f Q=%0.1f", et, sample_i, sample_q, ei, eq);
          end
        end
      end else if (sample_i != 0 || sample_q != 0) begin
        errors++;
        $display("FAIL R7 idle output: actual I=%0d Q=%0d expected I=0 Q=0", sample_i, sample_q);
      end
    end
  end

  // Driver: one enabled cycle per iteration, model updated from the requirements.
  task automatic run_pulse(input int n, input int ps_at, input string tag);
    logic [FW-1:0] p_new;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (c == LAT - 1) check_valid(1'b0, "R6");
      if (c == LAT)     check_valid(1'b1, "R6");
      tx_en = 1'b1;
      pulse_start = (c == ps_at);
      p_new = m_phase + m_freq;
      if (pulse_start || !m_en) m_freq = start_word;
      else                      m_freq = m_freq + incr_word;
      m_phase = p_new;
      m_en = 1'b1;
      push_expect(p_new, tag);
    end
  endtask

  task automatic stop_pulse(input int gap);
    @(negedge clk);
    tx_en = 1'b0;
    pulse_start = 1'b0;
    m_en = 1'b0;
    m_freq = '0;
    m_phase = '0;
    @(posedge clk);
    #1;
    exp_i.delete();
    exp_q.delete();
    exp_t.delete();
    repeat (gap - 1) @(posedge clk);
  endtask

  initial begin
    gain_half = 0.5;
    for (int k = 0; k < NS; k++) gain_half = gain_half * $sqrt(1.0 + 2.0 ** (-2 * k));

    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;  // R1: outputs quiet during reset
    if (sample_valid !== 1'b0 || sample_i !== 0 || sample_q !== 0) begin
      errors++;
      $display("FAIL R1 reset: actual v=%0b I=%0d Q=%0d expected 0 0 0", sample_valid, sample_i, sample_q);
    end
    rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1: still quiet after reset with tx_en low
    if (sample_valid !== 1'b0 || sample_i !== 0 || sample_q !== 0) begin
      errors++;
      $display("FAIL R1 post-reset: actual v=%0b I=%0d Q=%0d expected 0 0 0", sample_valid, sample_i, sample_q);
    end
    mon_on = 1'b1;

    // R2 R5 R4: negative start, upward ramp through every quadrant
    start_word = 32'hF000_0000;
    incr_word  = 32'h0010_0000;
    amplitude  = 16'sd20000;
    run_pulse(60, -1, "R2 R4 R5");
    stop_pulse(5);

    // R3 R9: restart mid-pulse, negative amplitude, downward ramp
    start_word = 32'h0800_0000;
    incr_word  = 32'hFFF0_0000;
    amplitude  = -16'sd12000;
    run_pulse(70, 30, "R3 R9 R4");
    stop_pulse(4);

    // R8: large words wrap the accumulators
    start_word = 32'h7FFF_F000;
    incr_word  = 32'h4000_0000;
    amplitude  = 16'sd32767;
    run_pulse(40, -1, "R8 R4");
    stop_pulse(1);

    // R7: one-cycle gap, then restart from phase 0; R9 with most negative code
    start_word = 32'hF800_0000;
    incr_word  = 32'h0004_0000;
    amplitude  = -16'sd32768;
    run_pulse(30, -1, "R7 R9 R5");
    stop_pulse(6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule